// File: doc/BRIEF.md
# Converter Fault and Hiccup Sequencer

This block supervises the protection behaviour of a synchronous buck regulator in the digital domain. The analog comparators deliver one flag per switching cycle for overcurrent, undervoltage and overvoltage. A thermal sensor delivers separate trip and release flags. Enable and a soft-start-complete flag come from the start-up circuit. A one-clock `tick` marks each PWM cycle boundary. All consecutive-cycle counting and state changes happen on ticks. Disable is the exception: it acts on any clock.

On the output side the block does four things:
- It cuts the high-side pulse at once when an overcurrent flag appears while the high-side switch conducts.
- It forces the low-side switch on while the output is over-voltage.
- It tristates the drivers on a disable, on an over-temperature trip, on a persistent overvoltage and during hiccup recovery.
- It drives the external soft-start capacitor through discharge and restart requests.

Hiccup recovery discharges the soft-start and then runs three throw-away soft-start ramps with the drivers off, so that the power switches can cool. Only the fourth ramp lets the output come up.

Top module: `conv_fault_seq`

## Requirements
- R1: `pulse_kill` is high in the same clock as `oc_flag` and `hs_on` are both high while `fault_state` is RUN (1). This holds during soft-start as well. In every other case it is low.
- R2: In RUN with `ss_done` high, `OC_LIMIT` consecutive ticks that each have `oc_flag` and `hs_on` high move `fault_state` to DISCHARGE (4). A tick without such a hit clears the count. Each state change is visible in the clock after the edge at which the tick was sampled.
- R3: While `ss_done` is low in RUN, overcurrent hits are not counted. The count stays at zero, so these hits never lead to hiccup.
- R4: DISCHARGE (4) lasts one tick. During it `ss_discharge` and `drv_tristate` are high. It is followed by DUMMY (5), which is tristated and ends at a tick with `ss_done` high by returning to DISCHARGE. After `DUMMY_RUNS` dummy ramps, DISCHARGE leads back to RUN.
- R5: `ss_restart` is high for exactly one clock. It rises together with a change of state into RUN from OFF, OVER-TEMP or DISCHARGE, and with a change into DUMMY. It is never high for a return from OV-CLAMP to RUN.
- R6: In RUN with `ss_done` high, `UV_LIMIT` consecutive undervoltage ticks enter DISCHARGE. While `ss_done` is low the undervoltage count stays at zero.
- R7: An `ov_flag` tick in RUN enters OV-CLAMP (2). In OV-CLAMP `lowside_force` is high and `drv_tristate` is low. A tick without `ov_flag` returns to RUN.
- R8: `OV_LIMIT` consecutive `ov_flag` ticks, counting the entry tick, enter OV-OFF (3), which is tristated. In OV-OFF, `UV_LIMIT` consecutive `uv_flag` ticks enter DISCHARGE.
- R9: An `ot_trip` tick in any state other than OVER-TEMP enters OVER-TEMP (6), which is tristated. Only an `ot_clear` tick leaves it, and the exit goes to RUN.
- R10: With `en` low at a clock edge, `fault_state` becomes OFF (0) with drivers tristated, and all counts clear. With `en` high, the next tick leaves OFF for RUN. State changes only on a tick or a disable.
- R11: When several conditions coincide, priority runs disable, then over-temperature, then overvoltage, then the hiccup limits, then normal operation.
- R12: After reset, `fault_state` is OFF and `drv_tristate` is high. `pulse_kill`, `ss_discharge`, `ss_restart` and `lowside_force` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock PWM cycle boundary strobe |
| en | input | 1 | Converter enable |
| ss_done | input | 1 | Soft-start ramp complete |
| hs_on | input | 1 | High-side switch currently conducting |
| oc_flag | input | 1 | Overcurrent comparator flag |
| uv_flag | input | 1 | Feedback below undervoltage threshold |
| ov_flag | input | 1 | Feedback above overvoltage threshold |
| ot_trip | input | 1 | Die temperature above trip point |
| ot_clear | input | 1 | Die temperature below release point |
| pulse_kill | output | 1 | Terminate current high-side pulse |
| ss_discharge | output | 1 | Discharge soft-start capacitor |
| ss_restart | output | 1 | One-clock request to start a soft-start ramp |
| lowside_force | output | 1 | Hold low-side switch on |
| drv_tristate | output | 1 | Tristate both gate drivers |
| fault_state | output | 3 | 0 OFF, 1 RUN, 2 OV-CLAMP, 3 OV-OFF, 4 DISCHARGE, 5 DUMMY, 6 OVER-TEMP |

## Verification
The bench builds the block with its default limits: eight overcurrent cycles, eight undervoltage cycles, thirty-two overvoltage cycles and three dummy ramps. At these small values every escalation path, including the full overvoltage-to-shutdown-to-hiccup chain and a complete four-ramp hiccup recovery, completes within a few hundred clocks. A soft-start emulator in the bench answers the discharge and restart requests. This lets the dummy ramps run closed-loop, and lets a long random phase with rare disables and thermal trips hit the coincident-fault priorities.

// File: rtl/conv_fault_seq.sv
module conv_fault_seq #(
  parameter int OC_LIMIT   = 8,
  parameter int UV_LIMIT   = 8,
  parameter int OV_LIMIT   = 32,
  parameter int DUMMY_RUNS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       ss_done,
  input  logic       hs_on,
  input  logic       oc_flag,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       ot_trip,
  input  logic       ot_clear,
  output logic       pulse_kill,
  output logic       ss_discharge,
  output logic       ss_restart,
  output logic       lowside_force,
  output logic       drv_tristate,
  output logic [2:0] fault_state
);

  localparam int OC_W = $clog2(OC_LIMIT + 1);
  localparam int UV_W = $clog2(UV_LIMIT + 1);
  localparam int OV_W = $clog2(OV_LIMIT + 1);
  localparam int DM_W = $clog2(DUMMY_RUNS + 1);

  localparam logic [2:0] S_OFF = 3'd0, S_RUN = 3'd1, S_OVCL = 3'd2, S_OVOFF = 3'd3,
                         S_DISCH = 3'd4, S_DUMMY = 3'd5, S_OTEMP = 3'd6;

  logic [2:0]    state, state_n;
  logic [OC_W-1:0] oc_cnt, oc_n;
  logic [UV_W-1:0] uv_cnt, uv_n;
  logic [OV_W-1:0] ov_cnt, ov_n;
  logic [DM_W-1:0] dm_cnt, dm_n;
  logic          restart_n;

  wire oc_hit  = oc_flag & hs_on & ss_done;
  wire uv_hit  = uv_flag & ss_done;
  wire oc_last = oc_hit && oc_cnt == OC_W'(OC_LIMIT - 1);
  wire uv_last = uv_hit && uv_cnt == UV_W'(UV_LIMIT - 1);

  always_comb begin
    state_n = state;
    oc_n    = oc_cnt;
    uv_n    = uv_cnt;
    ov_n    = ov_cnt;
    dm_n    = dm_cnt;
    if (!en) begin
      state_n = S_OFF;
      oc_n = '0; uv_n = '0; ov_n = '0; dm_n = '0;
    end else if (tick) begin
      if (ot_trip && state != S_OTEMP) begin
        state_n = S_OTEMP;
      end else begin
        case (state)
          S_OFF:   state_n = S_RUN;
          S_OTEMP: if (ot_clear) state_n = S_RUN;
          S_RUN: begin
            if (ov_flag) begin
              state_n = S_OVCL;
            end else if (oc_last || uv_last) begin
              state_n = S_DISCH;
              dm_n    = '0;
            end else begin
              oc_n = oc_hit ? oc_cnt + OC_W'(1) : '0;
              uv_n = uv_hit ? uv_cnt + UV_W'(1) : '0;
            end
          end
          S_OVCL: begin
            if (!ov_flag)                              state_n = S_RUN;
            else if (ov_cnt == OV_W'(OV_LIMIT - 1))    state_n = S_OVOFF;
            else                                       ov_n = ov_cnt + OV_W'(1);
          end
          S_OVOFF: begin
            if (uv_flag && uv_cnt == UV_W'(UV_LIMIT - 1)) begin
              state_n = S_DISCH;
              dm_n    = '0;
            end else begin
              uv_n = uv_flag ? uv_cnt + UV_W'(1) : '0;
            end
          end
          S_DISCH: state_n = (dm_cnt == DM_W'(DUMMY_RUNS)) ? S_RUN : S_DUMMY;
          S_DUMMY: if (ss_done) begin
            state_n = S_DISCH;
            dm_n    = dm_cnt + DM_W'(1);
          end
          default: state_n = S_OFF;
        endcase
      end
      if (state_n != state) begin
        oc_n = '0;
        uv_n = '0;
        ov_n = (state_n == S_OVCL) ? OV_W'(1) : '0;
      end
    end
  end

  assign restart_n = en && tick && state_n != state && state != S_OVCL &&
                     (state_n == S_RUN || state_n == S_DUMMY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_OFF;
      oc_cnt     <= '0;
      uv_cnt     <= '0;
      ov_cnt     <= '0;
      dm_cnt     <= '0;
      ss_restart <= 1'b0;
    end else begin
      state      <= state_n;
      oc_cnt     <= oc_n;
      uv_cnt     <= uv_n;
      ov_cnt     <= ov_n;
      dm_cnt     <= dm_n;
      ss_restart <= restart_n;
    end
  end

  assign pulse_kill    = (state == S_RUN) & oc_flag & hs_on;
  assign ss_discharge  = (state == S_DISCH);
  assign lowside_force = (state == S_OVCL);
  assign drv_tristate  = (state == S_OFF) | (state == S_OTEMP) | (state == S_OVOFF) |
                         (state == S_DISCH) | (state == S_DUMMY);
  assign fault_state   = state;

  assert_oc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state == S_RUN && !ss_done) |=> oc_cnt == '0);

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fault_state == S_OFF && drv_tristate));

  assert_change_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> ($past(tick) || !$past(en)));

  assert_ov_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OVCL && $past(state) == S_RUN) |-> $past(ov_flag && tick));

  assert_ovoff_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OVOFF && $past(state) == S_OVCL) |-> $past(ov_cnt) == OV_W'(OV_LIMIT - 1));

  assert_dummy_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && $past(state) == S_DISCH) |-> $past(dm_cnt) == DM_W'(DUMMY_RUNS));

  assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  assert_ot_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && ot_trip && state != S_OTEMP) |=> fault_state == S_OTEMP);

endmodule

// File: tb/conv_fault_seq_tb.sv
module conv_fault_seq_tb;
  localparam int OCL = 8, UVL = 8, OVL = 32, DMR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, en = 0, ss_done = 0, hs_on = 0, oc_flag = 0, uv_flag = 0;
  logic ov_flag = 0, ot_trip = 0, ot_clear = 0;
  logic pulse_kill, ss_discharge, ss_restart, lowside_force, drv_tristate;
  logic [2:0] fault_state;

  always #2 clk = ~clk;

  conv_fault_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .ss_done(ss_done), .hs_on(hs_on),
    .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag), .ot_trip(ot_trip),
    .ot_clear(ot_clear), .pulse_kill(pulse_kill), .ss_discharge(ss_discharge),
    .ss_restart(ss_restart), .lowside_force(lowside_force), .drv_tristate(drv_tristate),
    .fault_state(fault_state));

  int n_chk = 0, n_fail = 0, cycles = 0;
  int st = 0, occ = 0, uvc = 0, ovc = 0, dmc = 0, m_rs = 0;
  bit auto_ss = 0;
  int ss_timer = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      st = 0; occ = 0; uvc = 0; ovc = 0; dmc = 0; m_rs = 0;
    end else begin
      int nst;
      m_rs = 0;
      nst = st;
      if (!en) begin
        st = 0; occ = 0; uvc = 0; ovc = 0; dmc = 0;
      end else if (tick) begin
        if (ot_trip && st != 6) nst = 6;
        else if (st == 0) nst = 1;
        else if (st == 6) begin if (ot_clear) nst = 1; end
        else if (st == 1) begin
          if (ov_flag) nst = 2;
          else if ((oc_flag && hs_on && ss_done && occ + 1 >= OCL) ||
                   (uv_flag && ss_done && uvc + 1 >= UVL)) begin nst = 4; dmc = 0; end
          else begin
            occ = (oc_flag && hs_on && ss_done) ? occ + 1 : 0;
            uvc = (uv_flag && ss_done) ? uvc + 1 : 0;
          end
        end else if (st == 2) begin
          if (!ov_flag) nst = 1;
          else if (ovc + 1 >= OVL) nst = 3;
          else ovc++;
        end else if (st == 3) begin
          if (uv_flag && uvc + 1 >= UVL) begin nst = 4; dmc = 0; end
          else uvc = uv_flag ? uvc + 1 : 0;
        end else if (st == 4) nst = (dmc >= DMR) ? 1 : 5;
        else if (st == 5) begin if (ss_done) begin nst = 4; dmc++; end end
        if (nst != st) begin
          m_rs = ((nst == 1 || nst == 5) && st != 2) ? 1 : 0;
          occ = 0; uvc = 0;
          ovc = (nst == 2) ? 1 : 0;
          st = nst;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    int e_pk, e_ts;
    string stag;
    e_pk = (st == 1 && oc_flag && hs_on) ? 1 : 0;
    e_ts = (st == 0 || st == 3 || st == 4 || st == 5 || st == 6) ? 1 : 0;
    case (st)
      0: stag = "R10 state"; 2: stag = "R7 state"; 3: stag = "R8 state";
      4, 5: stag = "R4 state"; 6: stag = "R9 state"; default: stag = "R2 state";
    endcase
    chk(fault_state == 3'(st), stag, fault_state, st);
    chk(pulse_kill == e_pk[0], "R1 pulse_kill", pulse_kill, e_pk);
    chk(ss_restart == m_rs[0], "R5 ss_restart", ss_restart, m_rs);
    chk(lowside_force == (st == 2), "R7 lowside_force", lowside_force, st == 2);
    chk(drv_tristate == e_ts[0], "R10 drv_tristate", drv_tristate, e_ts);
    chk(ss_discharge == (st == 4), "R4 ss_discharge", ss_discharge, st == 4);
  endtask

  task automatic step(input bit t);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    compare();
    if (auto_ss) begin
      if (ss_discharge || ss_restart || !en) ss_timer = 0;
      else ss_timer++;
      ss_done = (ss_timer >= 6);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0);
      step(1'b1);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 200000);
    finish_up();
  end

  initial begin
    int n_disch, n_dummy, n_rs, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();
    // R12 reset state
    chk(fault_state == 3'd0, "R12 reset state", fault_state, 0);
    chk(drv_tristate == 1'b1 && !pulse_kill && !ss_discharge && !ss_restart && !lowside_force,
        "R12 reset outputs", {drv_tristate, pulse_kill, ss_discharge, ss_restart, lowside_force}, 16);

    en = 1; ticks(1);
    chk(fault_state == 3'd1 && ss_restart, "R10 start", {fault_state, ss_restart}, 3);

    // R1 R3: hits during soft-start kill pulses but are not counted
    oc_flag = 1; hs_on = 1; ticks(20);
    chk(fault_state == 3'd1, "R3 no hiccup in soft-start", fault_state, 1);
    chk(pulse_kill == 1'b1, "R1 kill in soft-start", pulse_kill, 1);

    // R2: count clears on a clean tick
    ss_done = 1; ticks(OCL - 1);
    oc_flag = 0; ticks(1);
    oc_flag = 1; ticks(OCL - 1);
    chk(fault_state == 3'd1, "R2 count cleared", fault_state, 1);
    ticks(1);
    chk(fault_state == 3'd4 && ss_discharge && drv_tristate, "R2 enter discharge", fault_state, 4);

    // R4 R5: full hiccup recovery
    oc_flag = 0; hs_on = 0; auto_ss = 1; ss_timer = 0; ss_done = 0;
    n_disch = 1; n_dummy = 0; n_rs = 0; prev = 4;
    for (int i = 0; i < 400 && fault_state != 3'd1; i++) begin
      step(i[0]);
      if (ss_restart) n_rs++;
      if (fault_state != 3'(prev)) begin
        if (fault_state == 3'd4) n_disch++;
        if (fault_state == 3'd5) n_dummy++;
      end
      prev = int'(fault_state);
    end
    chk(n_dummy == DMR, "R4 dummy ramps", n_dummy, DMR);
    chk(n_disch == DMR + 1, "R4 discharges", n_disch, DMR + 1);
    chk(n_rs == DMR + 1, "R5 restart pulses", n_rs, DMR + 1);
    chk(fault_state == 3'd1, "R4 back to run", fault_state, 1);

    // R6 undervoltage
    auto_ss = 0; ss_done = 0; uv_flag = 1; ticks(12);
    chk(fault_state == 3'd1, "R6 held in soft-start", fault_state, 1);
    ss_done = 1; ticks(UVL - 1);
    chk(fault_state == 3'd1, "R6 below limit", fault_state, 1);
    ticks(1);
    chk(fault_state == 3'd4, "R6 enter discharge", fault_state, 4);
    uv_flag = 0;

    // R10 disable at a non-tick clock
    en = 0; step(1'b0);
    chk(fault_state == 3'd0 && drv_tristate, "R10 disable", fault_state, 0);
    en = 1; ticks(1);

    // R7 overvoltage clamp
    ov_flag = 1; ticks(1);
    chk(fault_state == 3'd2 && lowside_force && !drv_tristate, "R7 clamp", fault_state, 2);
    ticks(4);
    ov_flag = 0; ticks(1);
    chk(fault_state == 3'd1 && !ss_restart, "R7 release no restart", {fault_state, ss_restart}, 2);

    // R8 overvoltage shutdown then undervoltage hiccup
    ov_flag = 1; ticks(OVL - 1);
    chk(fault_state == 3'd2, "R8 below limit", fault_state, 2);
    ticks(1);
    chk(fault_state == 3'd3 && drv_tristate, "R8 shutdown", fault_state, 3);
    ov_flag = 0; uv_flag = 1; ticks(UVL - 1);
    chk(fault_state == 3'd3, "R8 uv below limit", fault_state, 3);
    ticks(1);
    chk(fault_state == 3'd4, "R8 hiccup", fault_state, 4);
    uv_flag = 0;

    // R9 over-temperature from hiccup
    ticks(1);
    ot_trip = 1; ticks(1);
    chk(fault_state == 3'd6 && drv_tristate, "R9 trip", fault_state, 6);
    ot_trip = 0; ticks(3);
    chk(fault_state == 3'd6, "R9 hold", fault_state, 6);
    ot_clear = 1; ticks(1);
    chk(fault_state == 3'd1 && ss_restart, "R9 resume", {fault_state, ss_restart}, 3);
    ot_clear = 0;

    // R11 priorities
    oc_flag = 1; hs_on = 1; ticks(OCL - 1);
    ov_flag = 1; ticks(1);
    chk(fault_state == 3'd2, "R11 ov over oc", fault_state, 2);
    ot_trip = 1; ticks(1);
    chk(fault_state == 3'd6, "R11 ot over ov", fault_state, 6);
    en = 0; tick = 1; step(1'b1);
    chk(fault_state == 3'd0, "R11 disable over ot", fault_state, 0);
    oc_flag = 0; hs_on = 0; ov_flag = 0; ot_trip = 0;
    en = 1; ticks(1);

    // random phase, model compared every clock
    auto_ss = 1;
    for (int i = 0; i < 6000; i++) begin
      en       = ($urandom_range(299) != 0);
      hs_on    = $urandom_range(1);
      oc_flag  = ($urandom_range(3) != 0);
      uv_flag  = ($urandom_range(2) == 0);
      ov_flag  = ($urandom_range(9) < 7) ? (fault_state == 3'd2) : $urandom_range(1);
      ot_trip  = ($urandom_range(199) == 0);
      ot_clear = ($urandom_range(7) == 0);
      step($urandom_range(1));
    end
    finish_up();
  end
endmodule